// File: doc/BRIEF.md
# Final Energy Sum with Quad-Linear Encoding

This block is the last stage of the energy summation in the sum processor. Once per bunch crossing it takes three partial sums for each of three quantities: the scalar transverse energy ET and the two signed vector components EX and EY. It adds each set of three and clamps the magnitude of every total at the 4 TeV ceiling. Each total is then compressed into an 8-bit floating code made of a 2-bit range field and a 6-bit mantissa. An odd parity bit is attached to every output word.

Each partial sum comes with its own valid flag, and a partial whose flag is low counts as zero. A one-cycle strobe marks a new crossing. A small controller walks the data through four named states. IDLE waits for a strobe and goes to ADD on one. ADD registers the three totals and always goes to CLAMP. CLAMP registers sign and saturated magnitude and always goes to PACK. PACK registers the encoded words and raises the output valid flag. From PACK the controller returns to IDLE, or goes straight to ADD when a strobe arrives in that same cycle. Totals are in units of 1 GeV.

Top module: `qle_energy_sum`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is low and all three output words are zero until the first crossing is packed.
- R2: Each total is the sum of its three partial sums, and a partial whose valid flag bit is low contributes zero. Partial k is held in bits [k*14+13 : k*14] of its bus, and flag bit k belongs to it.
- R3: ET partials are unsigned. EX and EY partials are two's complement. For EX and EY the magnitude is encoded, and the sign bit is 1 exactly when the total is negative, so a zero total has sign 0.
- R4: A magnitude of 4095 GeV or more is clamped to 4095, which gives the all-ones code 0xFF.
- R5: The code is {range[1:0], mantissa[5:0]}. The range r is the smallest value in 0..3 for which (magnitude >> 2r) < 64, and the mantissa is magnitude >> 2r. The dropped low bits are truncated. The step sizes are therefore 1, 4, 16 and 64 GeV.
- R6: `et_word` is {parity, code}. `ex_word` and `ey_word` are {parity, sign, code}. The number of ones in each whole word is odd.
- R7: A strobe that is sampled in IDLE or PACK is captured at that clock edge. `out_valid` is then high for exactly the one cycle that follows the third clock edge after capture, and the words carry that crossing's results in that cycle.
- R8: A strobe that is sampled in ADD or CLAMP is dropped, so it produces no output pulse and does not alter the result in flight. A strobe sampled in PACK starts the next crossing with no gap, which gives one result every three cycles.
- R9: The output words keep their last value while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xing_strobe | input | 1 | New crossing present on the inputs |
| et_part | input | 42 | Three unsigned ET partial sums, 14 bits each |
| ex_part | input | 42 | Three signed EX partial sums, 14 bits each |
| ey_part | input | 42 | Three signed EY partial sums, 14 bits each |
| et_ok | input | 3 | Valid flags for the ET partials |
| ex_ok | input | 3 | Valid flags for the EX partials |
| ey_ok | input | 3 | Valid flags for the EY partials |
| out_valid | output | 1 | One-cycle pulse when new words are present |
| et_word | output | 9 | {parity, ET code} |
| ex_word | output | 10 | {parity, sign, EX code} |
| ey_word | output | 10 | {parity, sign, EY code} |

## Verification
Two things can happen in the same cycle. In PACK the block emits one crossing's words, and a strobe in that cycle captures the next crossing. The bench presents a second crossing exactly in the PACK cycle and also raises strobes carrying junk data during ADD and CLAMP. It then requires a first pulse that carries the first crossing, two quiet cycles, and a second pulse that carries the second crossing, with the junk nowhere visible. All other crossings are randomised with a fixed seed over every range of the code, together with directed values at each range edge and at saturation, and they are compared with a model held in the bench.

// File: rtl/qle_pkg.sv
package qle_pkg;

    localparam int QLE_RANGE_W = 2;
    localparam int QLE_MANT_W  = 6;
    localparam int QLE_CODE_W  = QLE_RANGE_W + QLE_MANT_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADD   = 2'd1,
        ST_CLAMP = 2'd2,
        ST_PACK  = 2'd3
    } qle_state_e;

endpackage

// File: rtl/qle_sum3.sv
module qle_sum3 #(
    parameter int PART_W    = 14,
    parameter int SUM_W     = 17,
    parameter bit SIGNED_IN = 1'b0
) (
    input  logic [3*PART_W-1:0] part,
    input  logic [2:0]          ok,
    output logic [SUM_W-1:0]    total
);
    localparam int EXT_W = SUM_W - PART_W;

    logic [SUM_W-1:0] ext [3];

    for (genvar k = 0; k < 3; k++) begin : g_term
        logic [PART_W-1:0] slice;
        assign slice = part[k*PART_W +: PART_W];
        if (SIGNED_IN) begin : g_sext
            assign ext[k] = ok[k] ? {{EXT_W{slice[PART_W-1]}}, slice} : '0;
        end else begin : g_zext
            assign ext[k] = ok[k] ? {{EXT_W{1'b0}}, slice} : '0;
        end
    end

    assign total = ext[0] + ext[1] + ext[2];

endmodule

// File: rtl/qle_clamp.sv
module qle_clamp #(
    parameter int SUM_W = 17,
    parameter int MAG_W = 12,
    parameter int SAT   = 4095
) (
    input  logic [SUM_W-1:0] total,
    output logic             neg,
    output logic [MAG_W-1:0] mag
);
    logic [SUM_W-1:0] absv;

    always_comb begin
        neg  = total[SUM_W-1];
        absv = neg ? (~total + SUM_W'(1)) : total;
        if (absv > SUM_W'(SAT)) begin
            mag = MAG_W'(SAT);
        end else begin
            mag = absv[MAG_W-1:0];
        end
    end

endmodule

// File: rtl/qle_encoder.sv
module qle_encoder #(
    parameter int MAG_W      = 12,
    parameter int RANGE_W    = 2,
    parameter int MANT_W     = 6,
    parameter int STEP_SHIFT = 2
) (
    input  logic                      sign,
    input  logic [MAG_W-1:0]          mag,
    output logic [RANGE_W+MANT_W-1:0] code,
    output logic                      parity
);
    localparam int RANGES = 2 ** RANGE_W;

    logic [RANGES-1:0] fits;
    logic [MANT_W-1:0] mant_r [RANGES];

    for (genvar r = 0; r < RANGES; r++) begin : g_range
        logic [MAG_W-1:0] shifted;
        assign shifted   = mag >> (r * STEP_SHIFT);
        assign fits[r]   = (shifted >> MANT_W) == '0;
        assign mant_r[r] = shifted[MANT_W-1:0];
    end

    always_comb begin
        code = '1;
        for (int r = RANGES - 1; r >= 0; r--) begin
            if (fits[r]) begin
                code = {RANGE_W'(r), mant_r[r]};
            end
        end
        parity = ~^{sign, code};
    end

endmodule

// File: rtl/qle_energy_sum.sv
module qle_energy_sum
    import qle_pkg::*;
#(
    parameter int PART_W     = 14,
    parameter int SAT_GEV    = 4095,
    parameter int STEP_SHIFT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  xing_strobe,
    input  logic [3*PART_W-1:0]   et_part,
    input  logic [3*PART_W-1:0]   ex_part,
    input  logic [3*PART_W-1:0]   ey_part,
    input  logic [2:0]            et_ok,
    input  logic [2:0]            ex_ok,
    input  logic [2:0]            ey_ok,
    output logic                  out_valid,
    output logic [QLE_CODE_W:0]   et_word,
    output logic [QLE_CODE_W+1:0] ex_word,
    output logic [QLE_CODE_W+1:0] ey_word
);
    localparam int NQ    = 3;
    localparam int SUM_W = PART_W + 3;
    localparam int MAG_W = $clog2(SAT_GEV + 1);

    qle_state_e state, nxt;
    logic       accept;

    logic [3*PART_W-1:0]   part_in  [NQ];
    logic [2:0]            ok_in    [NQ];
    logic [3*PART_W-1:0]   cap_part [NQ];
    logic [2:0]            cap_ok   [NQ];
    logic [SUM_W-1:0]      sum_w    [NQ];
    logic [SUM_W-1:0]      sum_q    [NQ];
    logic                  neg_w    [NQ];
    logic [MAG_W-1:0]      mag_w    [NQ];
    logic                  neg_q    [NQ];
    logic [MAG_W-1:0]      mag_q    [NQ];
    logic [QLE_CODE_W-1:0] code_w   [NQ];
    logic                  par_w    [NQ];

    assign part_in[0] = et_part;
    assign part_in[1] = ex_part;
    assign part_in[2] = ey_part;
    assign ok_in[0]   = et_ok;
    assign ok_in[1]   = ex_ok;
    assign ok_in[2]   = ey_ok;

    // Controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Controller: next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = xing_strobe ? ST_ADD : ST_IDLE;
            ST_ADD:   nxt = ST_CLAMP;
            ST_CLAMP: nxt = ST_PACK;
            ST_PACK:  nxt = xing_strobe ? ST_ADD : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    assign accept = xing_strobe && ((state == ST_IDLE) || (state == ST_PACK));

    // Datapath per quantity: 0 = ET, 1 = EX, 2 = EY
    for (genvar q = 0; q < NQ; q++) begin : g_qty
        qle_sum3 #(
            .PART_W    (PART_W),
            .SUM_W     (SUM_W),
            .SIGNED_IN (q != 0)
        ) u_sum (
            .part  (cap_part[q]),
            .ok    (cap_ok[q]),
            .total (sum_w[q])
        );

        qle_clamp #(
            .SUM_W (SUM_W),
            .MAG_W (MAG_W),
            .SAT   (SAT_GEV)
        ) u_clamp (
            .total (sum_q[q]),
            .neg   (neg_w[q]),
            .mag   (mag_w[q])
        );

        qle_encoder #(
            .MAG_W      (MAG_W),
            .RANGE_W    (QLE_RANGE_W),
            .MANT_W     (QLE_MANT_W),
            .STEP_SHIFT (STEP_SHIFT)
        ) u_enc (
            .sign   (neg_q[q]),
            .mag    (mag_q[q]),
            .code   (code_w[q]),
            .parity (par_w[q])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cap_part[q] <= '0;
                cap_ok[q]   <= '0;
                sum_q[q]    <= '0;
                neg_q[q]    <= 1'b0;
                mag_q[q]    <= '0;
            end else begin
                if (accept) begin
                    cap_part[q] <= part_in[q];
                    cap_ok[q]   <= ok_in[q];
                end
                if (state == ST_ADD) begin
                    sum_q[q] <= sum_w[q];
                end
                if (state == ST_CLAMP) begin
                    neg_q[q] <= neg_w[q];
                    mag_q[q] <= mag_w[q];
                end
            end
        end
    end

    // Controller: outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            et_word   <= '0;
            ex_word   <= '0;
            ey_word   <= '0;
        end else begin
            out_valid <= (state == ST_PACK);
            if (state == ST_PACK) begin
                et_word <= {par_w[0], code_w[0]};
                ex_word <= {par_w[1], neg_q[1], code_w[1]};
                ey_word <= {par_w[2], neg_q[2], code_w[2]};
            end
        end
    end

    // R7
    add_to_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ADD |=> state == ST_CLAMP);

    // R7
    valid_after_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(state) == ST_PACK);

    // R8
    busy_capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADD || state == ST_CLAMP) |=> $stable(cap_part[1]) && $stable(cap_ok[1]));

    // R6
    et_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ^et_word);

    // R6
    ex_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ^ex_word);

    // R6
    ey_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ^ey_word);

    // R3
    zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ex_word[QLE_CODE_W-1:0] == '0) |-> !ex_word[QLE_CODE_W]);

    // R4
    sat_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PACK && mag_q[0] == MAG_W'(SAT_GEV)) |=> et_word[QLE_CODE_W-1:0] == '1);

    // R9
    hold_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(et_word) && $stable(ex_word) && $stable(ey_word));

endmodule

// File: tb/sim_qle_energy_sum.sv
module sim_qle_energy_sum;

    localparam int PW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xing_strobe = 1'b0;
    logic [3*PW-1:0] et_part = '0, ex_part = '0, ey_part = '0;
    logic [2:0]    et_ok = '0, ex_ok = '0, ey_ok = '0;
    logic          out_valid;
    logic [8:0]    et_word;
    logic [9:0]    ex_word, ey_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    qle_energy_sum u0 (
        .clk(clk), .rst_n(rst_n), .xing_strobe(xing_strobe),
        .et_part(et_part), .ex_part(ex_part), .ey_part(ey_part),
        .et_ok(et_ok), .ex_ok(ex_ok), .ey_ok(ey_ok),
        .out_valid(out_valid), .et_word(et_word), .ex_word(ex_word), .ey_word(ey_word)
    );

    function automatic logic [7:0] enc(input int mag);
        int m;
        m = (mag > 4095) ? 4095 : mag;
        for (int r = 0; r < 4; r++) begin
            if ((m >> (2 * r)) < 64) return 8'((r << 6) | (m >> (2 * r)));
        end
        return 8'hFF;
    endfunction

    function automatic logic [8:0] et_exp(input int total);
        logic [7:0] c;
        c = enc(total);
        return {~^c, c};
    endfunction

    function automatic logic [9:0] s_exp(input int total);
        logic [7:0] c;
        logic       s;
        s = (total < 0);
        c = enc(s ? -total : total);
        return {~^{s, c}, s, c};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input int et[3], input int ex[3], input int ey[3],
                         input logic [2:0] eo, input logic [2:0] xo, input logic [2:0] yo);
        for (int k = 0; k < 3; k++) begin
            et_part[k*PW +: PW] = PW'(et[k]);
            ex_part[k*PW +: PW] = PW'(ex[k]);
            ey_part[k*PW +: PW] = PW'(ey[k]);
        end
        et_ok = eo; ex_ok = xo; ey_ok = yo;
        xing_strobe = 1'b1;
    endtask

    function automatic int tot(input int v[3], input logic [2:0] o);
        int s = 0;
        for (int k = 0; k < 3; k++) if (o[k]) s += v[k];
        return s;
    endfunction

    // One crossing: drive at a negedge, expect pulse after the fourth negedge
    task automatic xing(input int et[3], input int ex[3], input int ey[3],
                        input logic [2:0] eo, input logic [2:0] xo, input logic [2:0] yo,
                        input string tag);
        logic [8:0] e_et;
        logic [9:0] e_ex, e_ey;
        e_et = et_exp(tot(et, eo));
        e_ex = s_exp(tot(ex, xo));
        e_ey = s_exp(tot(ey, yo));
        apply(et, ex, ey, eo, xo, yo);
        @(negedge clk);
        xing_strobe = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, {"R7 early ", tag}, int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, {"R7 pulse ", tag}, int'(out_valid), 1);
        chk(et_word == e_et, {"R2/R5/R6 et ", tag}, int'(et_word), int'(e_et));
        chk(ex_word == e_ex, {"R3/R5/R6 ex ", tag}, int'(ex_word), int'(e_ex));
        chk(ey_word == e_ey, {"R3/R5/R6 ey ", tag}, int'(ey_word), int'(e_ey));
        @(negedge clk);
        chk(out_valid == 1'b0, {"R7 single ", tag}, int'(out_valid), 0);
    endtask

    function automatic int rnd_u();
        return int'($urandom % (32'd1 << ($urandom % 15)));
    endfunction

    function automatic int rnd_s();
        int v;
        v = int'($urandom % (32'd1 << ($urandom % 14)));
        return ($urandom % 2) ? -v : v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int z[3];
        int a[3];
        int b[3];
        int c[3];
        int d[3];
        logic [8:0] wa_et, wb_et;
        logic [9:0] wa_ex, wb_ex;
        void'($urandom(32'h1A2B3C4D));
        z = '{0, 0, 0};

        repeat (3) @(negedge clk);
        // R1 during reset
        chk(out_valid == 0 && et_word == 0 && ex_word == 0 && ey_word == 0, "R1 in reset", int'(et_word), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 0 && et_word == 0 && ex_word == 0 && ey_word == 0, "R1 after reset", int'(ex_word), 0);

        // R2 all flags low treats data as zero
        xing('{5000, 100, 7}, '{-300, 2000, 3}, '{11, 22, 33}, 3'b000, 3'b000, 3'b000, "R2 masked");
        // R2 partial masking
        xing('{10, 20, 30}, '{-5, 7, 100}, '{40, -50, 60}, 3'b101, 3'b011, 3'b110, "R2 some flags");
        // R5 range edges
        xing('{63, 0, 0}, '{-64, 0, 0}, '{255, 0, 0}, 3'b111, 3'b111, 3'b111, "R5 edge 63/64/255");
        xing('{256, 0, 0}, '{1023, 0, 0}, '{-1024, 0, 0}, 3'b111, 3'b111, 3'b111, "R5 edge 256/1023/1024");
        xing('{4031, 0, 0}, '{4032, 0, 0}, '{-4094, 0, 0}, 3'b111, 3'b111, 3'b111, "R5 top range");
        // R4 saturation
        xing('{16383, 16383, 16383}, '{-8192, -8192, -8192}, '{8191, 8191, 8191}, 3'b111, 3'b111, 3'b111, "R4 saturate");
        xing('{4095, 1, 0}, '{2000, 2095, 0}, '{-4095, 0, 0}, 3'b111, 3'b111, 3'b111, "R4 at 4095");
        // R3 zero total and sign
        xing('{0, 0, 0}, '{-7, 7, 0}, '{-1, 0, 0}, 3'b111, 3'b111, 3'b111, "R3 zero and -1");

        // R8/R7 back to back with dropped strobes
        a = '{100, 200, 300}; b = '{-50, -60, 10};
        c = '{1, 2, 3};       d = '{900, 0, 0};
        wa_et = et_exp(600);  wa_ex = s_exp(-100);
        wb_et = et_exp(6);    wb_ex = s_exp(900);
        apply(a, b, z, 3'b111, 3'b111, 3'b111);
        @(negedge clk);
        apply('{9999, 9999, 9999}, '{-999, 0, 0}, z, 3'b111, 3'b111, 3'b111);
        @(negedge clk);
        apply('{8888, 0, 0}, '{777, 0, 0}, z, 3'b111, 3'b111, 3'b111);
        @(negedge clk);
        apply(c, d, z, 3'b111, 3'b111, 3'b111);
        @(negedge clk);
        xing_strobe = 1'b0;
        chk(out_valid == 1 && et_word == wa_et, "R8 first et", int'(et_word), int'(wa_et));
        chk(ex_word == wa_ex, "R8 first ex", int'(ex_word), int'(wa_ex));
        @(negedge clk);
        chk(out_valid == 0, "R8 gap1", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 0 && et_word == wa_et, "R9 hold in gap", int'(et_word), int'(wa_et));
        @(negedge clk);
        chk(out_valid == 1 && et_word == wb_et, "R8 second et", int'(et_word), int'(wb_et));
        chk(ex_word == wb_ex, "R8 second ex", int'(ex_word), int'(wb_ex));
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(out_valid == 0 && et_word == wb_et && ex_word == wb_ex, "R8/R9 no extra pulse", int'(out_valid), 0);
        end

        // Random crossings
        for (int n = 0; n < 300; n++) begin
            int re[3];
            int rx[3];
            int ry[3];
            for (int k = 0; k < 3; k++) begin
                re[k] = rnd_u(); rx[k] = rnd_s(); ry[k] = rnd_s();
            end
            xing(re, rx, ry, 3'($urandom), 3'($urandom), 3'($urandom), "R2/R5 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule